// File: doc/BRIEF.md
# Toggle-Based Pulse Synchronizer

This block carries single-cycle event pulses from one clock domain into a second, unrelated clock domain. Each pulse on the source side inverts a toggle register in the source domain. The toggle level goes straight into a shift chain of synchronizing flops in the destination domain. The synchronized level is then compared with a copy of itself that is one destination cycle older, and the difference becomes a pulse one destination clock wide.

Because the event travels as a level change and not as a pulse, a pulse one source cycle wide still arrives when the destination clock is slower than the source clock. The caller has to keep successive events far enough apart that the destination domain sees every toggle level for at least two of its own cycles. Each domain has its own synchronous active-low reset.

Top module: `pulse_xfer`

## Requirements
- R1: While the source reset is low, `src_pulse` has no effect. Once both resets are released, no `dst_pulse` appears until a new source pulse arrives. `dst_pulse` is low in the first destination cycle after the destination reset is released.
- R2: Each source clock cycle in which `src_pulse` is high inverts the source toggle level exactly once. The level does not change in any cycle in which `src_pulse` is low.
- R3: Going from a slow source clock to a fast destination clock, every source pulse gives exactly one `dst_pulse`. This holds even when source pulses come in consecutive source cycles.
- R4: Going from a fast source clock to a slower destination clock, a source pulse one source cycle wide still gives exactly one `dst_pulse`, provided the pulses are spaced legally.
- R5: Every `dst_pulse` is high for exactly one destination clock cycle.
- R6: A `dst_pulse` rises on the second or third destination rising edge after the source edge that captured the pulse. It never rises unless the synchronized level has just changed.
- R7: Source pulses spaced at the legal minimum of two destination periods, plus margin, each give a separate `dst_pulse`. The output counts match the input counts, and no two output pulses are adjacent. Closer spacing breaks the input contract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source synchronous reset, active low |
| src_pulse | input | 1 | Event pulse, one source cycle per event |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination synchronous reset, active low |
| dst_pulse | output | 1 | Regenerated event, one destination cycle wide |

## Verification
Two functions can meet in the same destination cycle: the edge detector closing out one output pulse, and the synchronizer delivering the next toggle change. This is provoked by spacing source pulses at the smallest legal gap, and by firing source pulses in consecutive cycles into a faster destination. The run is judged by two things: the destination pulse count must equal the source pulse count, and a monitor on the output must never see two high samples in a row.

// File: rtl/pulse_xfer_pkg.sv
// Package: shared constants for the toggle pulse synchronizer.
// Assumes: none beyond the defaults it declares.
package pulse_xfer_pkg;
    // Default number of synchronizing flops in the destination domain.
    parameter int unsigned PX_DEF_STAGES = 2;
    // Smallest chain that still gives a settling stage.
    parameter int unsigned PX_MIN_STAGES = 2;
endpackage

// File: rtl/px_src_toggle.sv
// Module: source-domain toggle register.
// What it does: inverts a level register once per cycle with src_pulse high.
// Assumes: src_pulse is synchronous to src_clk; reset is synchronous, active low.
module px_src_toggle (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    output logic tgl_o
);
    logic tgl_q;

    // Flip the level on each accepted pulse; clear it on reset.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n)
            tgl_q <= 1'b0;
        else if (src_pulse)
            tgl_q <= ~tgl_q;
    end

    assign tgl_o = tgl_q;
endmodule

// File: rtl/px_sync_chain.sv
// Module: multi-flop level synchronizer in the destination domain.
// What it does: samples an asynchronous level through STAGES flops in series.
// Assumes: d_i comes straight from a flop in another domain, with no logic between.
module px_sync_chain #(
    parameter int unsigned STAGES = pulse_xfer_pkg::PX_DEF_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned SH_W = (STAGES < pulse_xfer_pkg::PX_MIN_STAGES)
                                   ? pulse_xfer_pkg::PX_MIN_STAGES : STAGES;

    logic [SH_W-1:0] sh_q;

    // Shift the incoming level one stage per destination cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= {sh_q[SH_W-2:0], d_i};
    end

    assign q_o = sh_q[SH_W-1];
endmodule

// File: rtl/px_edge_det.sv
// Module: change detector on a synchronized level.
// What it does: pulses for one cycle whenever the level differs from its value a cycle earlier.
// Assumes: lvl_i is already synchronous to clk.
module px_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic pulse_o
);
    logic dly_q;

    // Hold the previous cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dly_q <= 1'b0;
        else
            dly_q <= lvl_i;
    end

    // Either direction of change is one event.
    assign pulse_o = lvl_i ^ dly_q;
endmodule

// File: rtl/pulse_xfer.sv
// Module: toggle-based pulse synchronizer (top).
// What it does: moves one-cycle events from src_clk into dst_clk as one-cycle pulses.
// Assumes: events are at least two dst_clk periods apart; clocks are unrelated.
module pulse_xfer #(
    parameter int unsigned SYNC_STAGES = pulse_xfer_pkg::PX_DEF_STAGES
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic tgl_q;
    logic sync_lvl;

    // Source domain: event to level.
    px_src_toggle u_tgl (
        .src_clk  (src_clk),
        .src_rst_n(src_rst_n),
        .src_pulse(src_pulse),
        .tgl_o    (tgl_q)
    );

    // Crossing: level into destination domain.
    px_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (dst_clk),
        .rst_n(dst_rst_n),
        .d_i  (tgl_q),
        .q_o  (sync_lvl)
    );

    // Destination domain: level change to pulse.
    px_edge_det u_edge (
        .clk    (dst_clk),
        .rst_n  (dst_rst_n),
        .lvl_i  (sync_lvl),
        .pulse_o(dst_pulse)
    );
endmodule

// File: rtl/pulse_xfer_chk.sv
// Module: assertion checker for pulse_xfer, attached by bind.
// What it does: watches the toggle, the synchronized level and the output pulse.
// Assumes: stimulus respects the legal spacing of source events.
module pulse_xfer_chk (
    input logic src_clk,
    input logic src_rst_n,
    input logic src_pulse,
    input logic tgl,
    input logic dst_clk,
    input logic dst_rst_n,
    input logic sync_lvl,
    input logic dst_pulse
);
    // R1: output quiet in the first cycle out of reset.
    p_reset_quiet_r1: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        $rose(dst_rst_n) |-> !dst_pulse);

    // R2: each accepted pulse flips the toggle.
    p_toggle_flip_r2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_pulse |=> (tgl != $past(tgl)));

    // R2: no pulse, no change.
    p_toggle_hold_r2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !src_pulse |=> $stable(tgl));

    // R5: output is one destination cycle wide.
    p_one_wide_r5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_pulse |=> !dst_pulse);

    // R6: an output pulse needs a fresh change on the synchronized level.
    p_needs_change_r6: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_pulse |-> (sync_lvl != $past(sync_lvl)));
endmodule

bind pulse_xfer pulse_xfer_chk u_chk (
    .src_clk  (src_clk),
    .src_rst_n(src_rst_n),
    .src_pulse(src_pulse),
    .tgl      (tgl_q),
    .dst_clk  (dst_clk),
    .dst_rst_n(dst_rst_n),
    .sync_lvl (sync_lvl),
    .dst_pulse(dst_pulse)
);

// File: tb/pulse_xfer_tb_top.sv
`timescale 1ns/1ps
module pulse_xfer_tb_top;
    logic src_clk   = 1'b0;
    logic dst_clk   = 1'b0;
    logic src_rst_n = 1'b0;
    logic dst_rst_n = 1'b0;
    logic src_pulse = 1'b0;
    logic dst_pulse;

    int   checks = 0;
    int   errors = 0;
    int   dst_cnt = 0;
    int   wide_cnt = 0;
    logic prev_hi = 1'b0;
    bit   done = 1'b0;
    realtime dst_half = 3.65;

    pulse_xfer dut_i (
        .src_clk  (src_clk),
        .src_rst_n(src_rst_n),
        .src_pulse(src_pulse),
        .dst_clk  (dst_clk),
        .dst_rst_n(dst_rst_n),
        .dst_pulse(dst_pulse)
    );

    // 50 MHz source clock.
    always #10 src_clk = ~src_clk;

    // Destination clock, period chosen per test.
    initial begin
        #1.3;
        forever #(dst_half) dst_clk = ~dst_clk;
    end

    // Output monitor: counts pulses and flags adjacent highs.
    always @(negedge dst_clk) begin
        if (dst_rst_n && dst_pulse === 1'b1) begin
            dst_cnt <= dst_cnt + 1;
            if (prev_hi) wide_cnt <= wide_cnt + 1;
        end
        prev_hi <= dst_rst_n && (dst_pulse === 1'b1);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic reset_all(input realtime half);
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        src_pulse = 1'b0;
        dst_half  = half;
        repeat (4) @(negedge src_clk);
        repeat (4) @(negedge dst_clk);
        src_rst_n = 1'b1;
        @(negedge dst_clk);
        dst_rst_n = 1'b1;
        repeat (2) @(negedge dst_clk);
    endtask

    task automatic send(input int gap);
        @(negedge src_clk);
        src_pulse = 1'b1;
        @(negedge src_clk);
        src_pulse = 1'b0;
        repeat (gap) @(negedge src_clk);
    endtask

    task automatic drain();
        repeat (12) @(negedge dst_clk);
    endtask

    // R1: pulses during source reset are ignored; output quiet.
    task automatic t_reset();
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        dst_half  = 3.65;
        repeat (4) @(negedge dst_clk);
        chk("R1 dst_pulse in reset", int'(dst_pulse === 1'b1), 0);
        @(negedge src_clk); src_pulse = 1'b1;
        repeat (3) @(negedge src_clk); src_pulse = 1'b0;
        src_rst_n = 1'b1;
        @(negedge dst_clk);
        dst_rst_n = 1'b1;
        @(negedge dst_clk);
        chk("R1 first cycle after reset", int'(dst_pulse === 1'b1), 0);
        drain();
        chk("R1 no pulse after reset", dst_cnt, 0);
    endtask

    // R3, R6: slow-to-fast, latency and counts including back-to-back.
    task automatic t_slow_to_fast();
        int base;
        int n;
        reset_all(3.65);
        base = dst_cnt;
        @(negedge src_clk); src_pulse = 1'b1;
        @(posedge src_clk);
        @(negedge src_clk); src_pulse = 1'b0;
        n = 0;
        for (int i = 1; i <= 8; i++) begin
            if (n == 0) begin
                if (dst_pulse === 1'b1) n = i;
                else @(negedge dst_clk);
            end
        end
        if (dst_pulse === 1'b1 && n == 0) n = 8;
        chk("R6 latency lower bound", int'(n >= 1), 1);
        chk("R6 latency upper bound", int'(n > 0 && n <= 5), 1);
        drain();
        chk("R3 single pulse count", dst_cnt - base, 1);
        base = dst_cnt;
        for (int k = 0; k < 5; k++) begin
            @(negedge src_clk); src_pulse = 1'b1;
        end
        @(negedge src_clk); src_pulse = 1'b0;
        send(3);
        send(0);
        drain();
        chk("R3 back-to-back count", dst_cnt - base, 7);
        chk("R5 width slow-to-fast", wide_cnt, 0);
    endtask

    // R4: fast-to-slow, single-cycle pulses with legal gaps.
    task automatic t_fast_to_slow();
        int base;
        reset_all(23.65);
        base = dst_cnt;
        send(9);
        send(12);
        send(8);
        send(20);
        drain();
        chk("R4 fast-to-slow count", dst_cnt - base, 4);
        chk("R5 width fast-to-slow", wide_cnt, 0);
    endtask

    // R7: minimal legal spacing keeps pulses distinct.
    task automatic t_min_spacing();
        int base;
        reset_all(23.65);
        base = dst_cnt;
        for (int k = 0; k < 10; k++) send(7);
        drain();
        chk("R7 min-spacing count", dst_cnt - base, 10);
        chk("R7 no adjacent pulses", wide_cnt, 0);
    endtask

    initial begin
        t_reset();
        t_slow_to_fast();
        t_fast_to_slow();
        t_min_spacing();
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2ms;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule